// File: doc/BRIEF.md
# Serial Unlock Key Detector

This block sits on the target side of a two-wire serial programming link (a clock line and a data line). It watches the pair for a fixed 32-bit unlock word. When the word arrives, it switches the device into programming mode. The switch happens only while an active-low hold pin is driven low and a non-volatile enable bit permits low-voltage entry. The serial clock, serial data and hold pin are asynchronous to the system clock. They pass through a synchronizer first, and each data bit is taken on a falling edge of the synchronized serial clock.

The comparison uses a sliding window: every sampled bit is checked against the key together with the bits before it. A programmer therefore needs no start marker and may send any bits before the word. On entry the block gives a single-cycle entry pulse, which downstream logic uses to reset itself and to clear its programming address to zero. Programming mode then stays set for as long as the hold pin stays low. Releasing the pin ends the mode and empties the window.

Top module: `key_unlock_det`

## Requirements
- R1: After reset, `prog_mode_o` and `entry_pulse_o` are 0.
- R2: When the 32 bits of the value 32'h4D434850 arrive in the window bit 0 first and bit 31 last, the block enters programming mode, provided `hold_n_i` is low and `lv_en_i` is 1.
- R3: A data bit is taken only on a falling edge of the synchronized serial clock. A data value that is present at the rising edge and replaced before the falling edge is never used.
- R4: `entry_pulse_o` is high for exactly one cycle, in the same cycle in which `prog_mode_o` rises, and at no other time.
- R5: While `lv_en_i` is 0, no key match enters programming mode.
- R6: While the synchronized `hold_n_i` is high, no key match enters programming mode. A synchronized high on `hold_n_i` clears programming mode on the next clock edge.
- R7: Any number of bits may come before the key. The match is checked after every sampled bit, over the newest 32 bits.
- R8: While in programming mode, the block ignores further key words: `prog_mode_o` stays 1 and `entry_pulse_o` stays 0.
- R9: The window is cleared to all zeros whenever detection is not armed, that is, when the hold pin is released, when the enable is 0, or while in programming mode. A partial key sent before a release therefore cannot be completed after it.
- R10: With SYNC_STAGES synchronizer flops, `prog_mode_o` rises SYNC_STAGES+1 clock edges after the first edge that sees the falling serial-clock input carrying the last key bit. It falls SYNC_STAGES+1 edges after the first edge that sees `hold_n_i` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the programmer, asynchronous |
| ser_dat_i | input | 1 | Serial data from the programmer, asynchronous |
| hold_n_i | input | 1 | Active-low mode-hold pin, asynchronous |
| lv_en_i | input | 1 | Configuration bit that permits key entry (1 = allowed) |
| prog_mode_o | output | 1 | High while programming mode is active |
| entry_pulse_o | output | 1 | One-cycle pulse on mode entry, resets downstream state |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This checks that the synchronizer generate loop and the entry and exit latencies follow the parameter, and not a hard-wired two-flop delay. The key is left at its default 32-bit value. At that width, a sliding match behind leading junk bits, a partial key split by a hold release, and a skewed data line whose rising-edge value differs from its falling-edge value can all be driven through the ports within a few hundred cycles each.

// File: rtl/kud_pkg.sv
package kud_pkg;
   // Bundle of the asynchronous serial lines, kept together so that they share one synchronizer.
   typedef struct packed {
      logic sclk;
      logic sdat;
      logic hold_n;
   } ser_lines_t;

   localparam int unsigned LINES_W = $bits(ser_lines_t);
   // Reset value of the bundle: the clock and data lines idle low, the hold pin idles released (high).
   localparam ser_lines_t LINES_IDLE = '{sclk: 1'b0, sdat: 1'b0, hold_n: 1'b1};
   localparam logic [31:0] DEFAULT_KEY = 32'h4D434850;
endpackage

// File: rtl/kud_sync.sv
module kud_sync #(
   parameter int unsigned WIDTH = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic [WIDTH-1:0] r;
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= RST_VAL;
               else        r <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= RST_VAL;
               else        r <= g_stage[i-1].r;
            end
         end
      end
   endgenerate

   assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/kud_fall_det.sv
module kud_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign fall = prev_q & ~lvl;
endmodule

// File: rtl/kud_key_window.sv
module kud_key_window #(
   parameter int unsigned KEY_W = 32,
   parameter logic [KEY_W-1:0] KEY_VAL = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic shift,
   input  logic bit_in,
   output logic hit
);
   logic [KEY_W-1:0] win_q;
   logic [KEY_W-1:0] win_nxt;

   // The newest bit enters at the top, so the oldest bit (the first one sent) ends up in bit 0.
   assign win_nxt = {bit_in, win_q[KEY_W-1:1]};
   assign hit     = ~clear & shift & (win_nxt == KEY_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     win_q <= '0;
      else if (clear) win_q <= '0;
      else if (shift) win_q <= win_nxt;
   end
endmodule

// File: rtl/key_unlock_det.sv
module key_unlock_det
   import kud_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned KEY_W = 32,
   parameter logic [KEY_W-1:0] KEY_VAL = KEY_W'(DEFAULT_KEY)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_clk_i,
   input  logic ser_dat_i,
   input  logic hold_n_i,
   input  logic lv_en_i,
   output logic prog_mode_o,
   output logic entry_pulse_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("key_unlock_det: SYNC_STAGES must be at least 2");
      end
      if (KEY_W < 8) begin : g_bad_key
         $error("key_unlock_det: KEY_W must be at least 8");
      end
   endgenerate

   ser_lines_t raw_lines, syn_lines;
   logic       sclk_fall;
   logic       armed;
   logic       key_hit;
   logic       mode_q, pulse_q;

   assign raw_lines = '{sclk: ser_clk_i, sdat: ser_dat_i, hold_n: hold_n_i};

   kud_sync #(
      .WIDTH  (LINES_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(LINES_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_lines),
      .q    (syn_lines)
   );

   kud_fall_det u_fall (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (syn_lines.sclk),
      .fall (sclk_fall)
   );

   // Detection is armed only while the pin is held, entry is allowed and the mode is not yet active.
   assign armed = ~syn_lines.hold_n & lv_en_i & ~mode_q;

   kud_key_window #(
      .KEY_W  (KEY_W),
      .KEY_VAL(KEY_VAL)
   ) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (~armed),
      .shift (sclk_fall),
      .bit_in(syn_lines.sdat),
      .hit   (key_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (syn_lines.hold_n) begin
            mode_q <= 1'b0;
         end else if (key_hit) begin
            mode_q  <= 1'b1;
            pulse_q <= 1'b1;
         end
      end
   end

   assign prog_mode_o   = mode_q;
   assign entry_pulse_o = pulse_q;
endmodule

// File: rtl/kud_checker.sv
module kud_checker (
   input logic clk,
   input logic rst_n,
   input logic lv_en,
   input logic hold_s,
   input logic fall,
   input logic prog_mode,
   input logic entry_pulse
);
   assert_rise_gives_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_mode) |-> entry_pulse);
   assert_pulse_only_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      entry_pulse |-> $rose(prog_mode));
   assert_pulse_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      entry_pulse |=> !entry_pulse);
   assert_entry_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_mode) |-> $past(lv_en));
   assert_entry_needs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_mode) |-> !$past(hold_s));
   assert_release_exits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_s |=> !prog_mode);
   assert_entry_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_mode) |-> $past(fall));
   assert_no_reentry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      prog_mode |=> !entry_pulse);
endmodule

bind key_unlock_det kud_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lv_en      (lv_en_i),
   .hold_s     (syn_lines.hold_n),
   .fall       (sclk_fall),
   .prog_mode  (prog_mode_o),
   .entry_pulse(entry_pulse_o)
);

// File: tb/sim_key_unlock_det.sv
`timescale 1ns/1ps
module sim_key_unlock_det;
   localparam int STG = 3;
   localparam int HP = 4;
   localparam int KW = 32;
   localparam logic [31:0] KEY = 32'h4D434850;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, hold_n = 1'b1, lv_en = 1'b0;
   logic prog_mode, entry_pulse;

   int n_cmp = 0, n_bad = 0, n_pulses = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   key_unlock_det #(.SYNC_STAGES(STG)) u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
      .hold_n_i(hold_n), .lv_en_i(lv_en), .prog_mode_o(prog_mode), .entry_pulse_o(entry_pulse)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [2:0] hist[$];
   bit         bits[$];
   logic       sc1, sd1, sh1, sc2;
   logic       m_mode, m_pulse;

   function automatic bit window_is_key();
      for (int i = 0; i < KW; i++)
         if (bits[i] != KEY[i]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic zero_window();
      bits.delete();
      for (int i = 0; i < KW; i++) bits.push_back(1'b0);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         sc1 = 1'b0; sd1 = 1'b0; sh1 = 1'b1; sc2 = 1'b0;
         m_mode = 1'b0; m_pulse = 1'b0;
         zero_window();
      end else begin
         logic f, arm, h;
         logic [2:0] s;
         f = sc2 & ~sc1;
         arm = ~sh1 & lv_en & ~m_mode;
         h = 1'b0;
         if (!arm) zero_window();
         else if (f) begin
            bits.push_back(sd1);
            void'(bits.pop_front());
            h = window_is_key();
         end
         m_pulse = h;
         if (sh1) m_mode = 1'b0;
         else if (h) m_mode = 1'b1;
         hist.push_back({ser_clk, ser_dat, hold_n});
         if (hist.size() > STG) void'(hist.pop_front());
         s = (hist.size() == STG) ? hist[0] : 3'b001;
         sc2 = sc1;
         sc1 = s[2]; sd1 = s[1]; sh1 = s[0];
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check({cur_req, " mode vs model"}, prog_mode, m_mode);
         check({cur_req, " pulse vs model"}, entry_pulse, m_pulse);
         if (entry_pulse) n_pulses++;
      end
   end

   // ---------------- stimulus ----------------
   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(logic b);
      ser_dat = b; ser_clk = 1'b1;
      wait_cyc(HP);
      ser_clk = 1'b0;
      wait_cyc(HP);
   endtask

   // Rising edge carries the inverted bit; the true bit settles before the falling edge.
   task automatic send_bit_skew(logic b);
      ser_dat = ~b; ser_clk = 1'b1;
      wait_cyc(HP / 2);
      ser_dat = b;
      wait_cyc(HP - HP / 2);
      ser_clk = 1'b0;
      wait_cyc(HP);
   endtask

   task automatic send_range(logic [31:0] w, int lo, int hi);
      for (int i = lo; i <= hi; i++) send_bit(w[i]);
   endtask

   task automatic release_hold();
      hold_n = 1'b1;
      wait_cyc(STG + 3);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int p0;
      wait_cyc(4);
      check("R1 reset mode", prog_mode, 1'b0);
      check("R1 reset pulse", entry_pulse, 1'b0);
      rst_n = 1'b1;
      wait_cyc(3);

      cur_req = "R5";
      lv_en = 1'b0; hold_n = 1'b0;
      wait_cyc(STG + 2);
      send_range(KEY, 0, 31);
      wait_cyc(STG + 3);
      check("R5 disabled no entry", prog_mode, 1'b0);
      release_hold();

      cur_req = "R6";
      lv_en = 1'b1; hold_n = 1'b1;
      send_range(KEY, 0, 31);
      wait_cyc(STG + 3);
      check("R6 hold released no entry", prog_mode, 1'b0);

      cur_req = "R2";
      hold_n = 1'b0;
      wait_cyc(STG + 2);
      send_range(KEY, 0, 30);
      ser_dat = KEY[31]; ser_clk = 1'b1;
      wait_cyc(HP);
      ser_clk = 1'b0;
      wait_cyc(STG);
      check("R10 mode not yet", prog_mode, 1'b0);
      wait_cyc(1);
      check("R2 key enters mode", prog_mode, 1'b1);
      check("R4 pulse with rise", entry_pulse, 1'b1);
      wait_cyc(1);
      check("R4 pulse one cycle", entry_pulse, 1'b0);
      wait_cyc(HP);

      cur_req = "R8";
      p0 = n_pulses;
      send_range(KEY, 0, 31);
      wait_cyc(STG + 3);
      check("R8 mode held", prog_mode, 1'b1);
      check("R8 no second pulse", n_pulses, p0);

      cur_req = "R6";
      hold_n = 1'b1;
      wait_cyc(STG);
      check("R10 exit not yet", prog_mode, 1'b1);
      wait_cyc(1);
      check("R6 release exits", prog_mode, 1'b0);
      wait_cyc(3);

      cur_req = "R7";
      hold_n = 1'b0;
      wait_cyc(STG + 2);
      send_range(32'h00001B6D, 0, 12);
      send_range(KEY, 0, 31);
      wait_cyc(STG + 3);
      check("R7 sliding match", prog_mode, 1'b1);
      release_hold();

      cur_req = "R9";
      hold_n = 1'b0;
      wait_cyc(STG + 2);
      send_range(KEY, 0, 15);
      release_hold();
      hold_n = 1'b0;
      wait_cyc(STG + 2);
      send_range(KEY, 16, 31);
      wait_cyc(STG + 3);
      check("R9 stale half key rejected", prog_mode, 1'b0);
      release_hold();

      cur_req = "R3";
      hold_n = 1'b0;
      wait_cyc(STG + 2);
      for (int i = 0; i < 32; i++) send_bit_skew(KEY[i]);
      wait_cyc(STG + 3);
      check("R3 falling edge sample", prog_mode, 1'b1);
      release_hold();
      check("R3 exit after skew run", prog_mode, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule